// File: doc/BRIEF.md
# Real-time clock interrupt status and mask unit

This unit sits between the event sources of a real-time clock and the system interrupt controller. The clock and alarm logic signal events as single-cycle pulses, and the unit latches each pulse into a sticky status bit. Software reads which events have happened and clears them by writing ones to a separate clear register.

The interrupt mask is never written directly. Software sets mask bits through an enable register, clears them through a disable register, and reads the result back through a read-only mask register. A single level interrupt is high whenever some status bit is both set and enabled. This lets several software contexts change their own mask bits without a read-modify-write race. A shared interrupt line can then be shared safely.

The register bus is minimal: a write strobe, an address and write data, plus read data that follows the address within the same cycle.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset every status bit and every mask bit is zero, and `irq_o` is low.
- R2: An event pulse on `evt_i[k]` sets status bit k at the next clock edge. The bit then stays set until it is cleared. Bit 0 is update acknowledge, bit 1 is alarm, bit 2 is second event, bit 3 is time event and bit 4 is calendar event.
- R3: A write to offset 0x1C clears each status bit whose write-data bit is one. Status bits whose write-data bit is zero keep their value.
- R4: If an event arrives in the same cycle as a clear of that bit, the event wins and the bit is set after the edge.
- R5: A write to offset 0x20 sets each mask bit whose write-data bit is one. Mask bits written with zero are left unchanged.
- R6: A write to offset 0x24 clears each mask bit whose write-data bit is one. Mask bits written with zero are left unchanged.
- R7: Reading offset 0x18 returns the status bits and reading offset 0x28 returns the mask bits, each in bits [4:0]. Writes to either offset change nothing.
- R8: `irq_o` is high exactly when the bitwise AND of status and mask is non-zero. It follows the registered state with no extra delay.
- R9: Reads of the write-only offsets 0x1C, 0x20 and 0x24, and reads of any unmapped offset, return zero.
- R10: Write-data bits above bit 4 have no effect, and read-data bits above bit 4 are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 5 | Single-cycle event pulses, one per status bit |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, available in the same cycle |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench drives clears and events into the same bit in the same cycle. A design that gave the clear priority would lose that event, and the bench would see a status bit read back as zero. Clear, enable and disable writes mix ones and zeros in their data. A design that wrote the register directly, instead of only setting or only clearing, would wipe out the bits written as zero. The bench also writes to the status and mask offsets, puts ones in the unused upper data bits, and reads the write-only and unmapped offsets. It therefore catches a register that accepts writes it should ignore and a read path that leaks state onto the wrong offset.

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int NUM_EVT = 5,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter logic [ADDR_W-1:0] OFS_STAT = 'h18,
  parameter logic [ADDR_W-1:0] OFS_CLR  = 'h1C,
  parameter logic [ADDR_W-1:0] OFS_EN   = 'h20,
  parameter logic [ADDR_W-1:0] OFS_DIS  = 'h24,
  parameter logic [ADDR_W-1:0] OFS_MASK = 'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o
);

  localparam int PAD_W = DATA_W - NUM_EVT;

  logic [NUM_EVT-1:0] status_q, mask_q;
  logic [NUM_EVT-1:0] wbits;
  logic hit_clr, hit_en, hit_dis;

  assign wbits   = wdata[NUM_EVT-1:0];
  assign hit_clr = wr_en && (addr == OFS_CLR);
  assign hit_en  = wr_en && (addr == OFS_EN);
  assign hit_dis = wr_en && (addr == OFS_DIS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= (status_q & ~(hit_clr ? wbits : '0)) | evt_i;
      if (hit_en)
        mask_q <= mask_q | wbits;
      else if (hit_dis)
        mask_q <= mask_q & ~wbits;
    end
  end

  always_comb begin
    if (addr == OFS_STAT)
      rdata = {{PAD_W{1'b0}}, status_q};
    else if (addr == OFS_MASK)
      rdata = {{PAD_W{1'b0}}, mask_q};
    else
      rdata = '0;
  end

  assign irq_o = |(status_q & mask_q);

  // R2
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  // R3
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_clr |=> ((status_q & $past(wbits & ~evt_i)) == '0));

  // R5
  en_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_en |=> ((mask_q & $past(wbits)) == $past(wbits)));

  // R6
  dis_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_dis |=> ((mask_q & $past(wbits)) == '0));

  // R7
  ro_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_STAT && evt_i == '0) |=> $stable(status_q));

  // R8
  irq_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(status_q) && $stable(mask_q)) |-> $stable(irq_o));

endmodule

// File: tb/test_rtc_irq_ctrl.sv
module test_rtc_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  evt_i = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  logic [4:0] m_stat = '0, m_mask = '0;

  always #4 clk = ~clk;

  rtc_irq_ctrl i_rtc_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o));

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a == 8'h18) return {27'd0, m_stat};
    if (a == 8'h28) return {27'd0, m_mask};
    return 32'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle(input string req, input logic [4:0] e, input logic w,
                       input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    evt_i = e; wr_en = w; addr = a; wdata = d;
    #1;
    check(req, rdata, exp_read(a));
    check("R8", {31'd0, irq_o}, {31'd0, |(m_stat & m_mask)});
    @(posedge clk);
    if (w && a == 8'h1C) m_stat = m_stat & ~d[4:0];
    m_stat = m_stat | e;
    if (w && a == 8'h20) m_mask = m_mask | d[4:0];
    else if (w && a == 8'h24) m_mask = m_mask & ~d[4:0];
  endtask

  task automatic rd(input string req, input logic [7:0] a);
    cycle(req, 5'd0, 1'b0, a, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] addrs [8];
    void'($urandom(32'd2024));
    addrs = '{8'h18, 8'h1C, 8'h20, 8'h24, 8'h28, 8'h00, 8'h2C, 8'h19};
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("R1", {31'd0, irq_o}, 32'd0);
    rst_n = 1'b1;
    // R1 reset state via reads
    rd("R1", 8'h18);
    rd("R1", 8'h28);
    // R2 each event bit sets and stays
    for (int k = 0; k < 5; k++) cycle("R2", 5'd1 << k, 1'b0, 8'h00, 32'd0);
    rd("R2", 8'h18);
    // R3 clear with mixed ones and zeros
    cycle("R3", 5'd0, 1'b1, 8'h1C, 32'h0000_0005);
    rd("R3", 8'h18);
    // R4 event and clear collide on bit 1
    cycle("R4", 5'b00010, 1'b1, 8'h1C, 32'h0000_0002);
    rd("R4", 8'h18);
    // R5 enable, R6 disable, with mixed data
    cycle("R5", 5'd0, 1'b1, 8'h20, 32'h0000_0012);
    rd("R5", 8'h28);
    cycle("R5", 5'd0, 1'b1, 8'h20, 32'h0000_0001);
    rd("R5", 8'h28);
    cycle("R6", 5'd0, 1'b1, 8'h24, 32'h0000_0010);
    rd("R6", 8'h28);
    // R7 writes to status and mask offsets ignored
    cycle("R7", 5'd0, 1'b1, 8'h18, 32'hFFFF_FFFF);
    rd("R7", 8'h18);
    cycle("R7", 5'd0, 1'b1, 8'h28, 32'h0000_0000);
    rd("R7", 8'h28);
    // R9 write-only and unmapped reads
    rd("R9", 8'h1C); rd("R9", 8'h20); rd("R9", 8'h24); rd("R9", 8'h2C);
    // R10 upper data bits
    cycle("R10", 5'd0, 1'b1, 8'h20, 32'hFFFF_FFE0);
    rd("R10", 8'h28);
    cycle("R10", 5'd0, 1'b1, 8'h1C, 32'hFFFF_FFE0);
    rd("R10", 8'h18);
    // R8 irq drops when status cleared
    cycle("R8", 5'd0, 1'b1, 8'h1C, 32'h0000_001F);
    rd("R8", 8'h18);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] e;
      e = (($urandom % 4) == 0) ? 5'($urandom) : 5'd0;
      cycle("R3", e, 1'($urandom), addrs[$urandom % 8], $urandom);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule